// File: doc/BRIEF.md
# ADC Test Pattern Checker

This block sits behind the deserializer of a single-lane ADC link and checks every 12-bit sample against a chosen test pattern. Four pattern types are supported: two alternating fixed words, a slow ramp whose code holds for four samples before it steps, a repeating eight-entry sine-like sequence, and a word programmed by the user. For the ramp and the sine sequence, the checker finds the phase of the incoming stream by itself. It then needs a run of matching samples before it asserts lock.

Once locked, every mismatching sample raises a one-cycle error pulse and advances a saturating error counter. A short run of consecutive mismatches drops lock and restarts acquisition. A bring-up engineer can select a pattern, wait for lock and read the counter to judge link quality. Mismatches seen before lock are not counted, so the time spent finding the phase never shows up as errors.

Top module: `tpat_checker`

## Requirements
- R1: After reset, `locked`, `err_pulse` and `err_count` are all zero.
- R2: With `mode` = 0 (alternating), the first sample equal to 0x555 or 0xAAA seeds the model and is not compared. From then on, the expected word is the bitwise inverse of the previous expected word. A first word that is neither value is skipped.
- R3: With `mode` = 1 (ramp), the first sample seeds a code, and the model synchronizes on the first later sample equal to that code plus one; that sample is not compared. Each code is then expected for exactly four samples before it steps by one, and 4095 steps to 0. A stream that steps on every sample never locks.
- R4: With `mode` = 2 (sine), the expected cycle is 1384, 978, 0, 3117, 2711, 3117, 0, 978. The model synchronizes on a sample equal to 1384, which is not compared, and expects 978 next.
- R5: With `mode` = 3 (custom), every valid sample is compared with `custom_word` and no acquisition step is needed.
- R6: `locked` rises after 16 consecutive matching compared samples. While unlocked, a compared mismatch clears the run and restarts acquisition.
- R7: While locked, four consecutive mismatches drop `locked`. Errors are counted only for mismatches seen while locked, the fourth one included.
- R8: `err_pulse` is high for the one cycle after the clock edge that takes a counted mismatch, and `err_count` steps by one at that same edge.
- R9: `err_count` is CNT_W bits wide (16 by default) and holds at its all-ones value.
- R10: `clr` zeroes `err_count` at the next edge and leaves `locked` alone. A change of `mode` zeroes `err_count`, drops `locked` and restarts acquisition.
- R11: A cycle with `smp_valid` low has no effect on the error pulse, the counter or the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clears the error counter |
| mode | input | 2 | Pattern select: 0 alternating, 1 ramp, 2 sine, 3 custom |
| custom_word | input | DW | Expected word in custom mode |
| smp_valid | input | 1 | Qualifies `smp_data` for one sample |
| smp_data | input | DW | Deserialized sample, unsigned |
| locked | output | 1 | Pattern lock indicator |
| err_pulse | output | 1 | One-cycle pulse per counted mismatch |
| err_count | output | CNT_W | Saturating error count |

## Verification
Both alternating start words are swept, along with one illegal first word, to separate seeding from comparison. Every one of the four ramp phases runs across the 4095-to-0 wrap, and a ramp that steps on every sample shows that the four-sample hold is enforced. All eight sine phases prove the single sync point, and injected bad samples show when the error pulse and the counter respond. In custom mode, repeated runs of misses walk through lock loss, relock, saturation on a narrow counter, clear and mode change.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

   typedef enum logic [1:0] {
      PAT_ALT    = 2'd0,
      PAT_RAMP   = 2'd1,
      PAT_SINE   = 2'd2,
      PAT_CUSTOM = 2'd3
   } pat_mode_e;

   localparam int SINE_LEN = 8;

   // Eight-entry sine-like cycle; entry 0 is the only value used for sync.
   function automatic logic [11:0] sine_code(input int idx);
      case (idx)
         0:       return 12'd1384;
         1:       return 12'd978;
         2:       return 12'd0;
         3:       return 12'd3117;
         4:       return 12'd2711;
         5:       return 12'd3117;
         6:       return 12'd0;
         default: return 12'd978;
      endcase
   endfunction

endpackage

// File: rtl/tpat_expect.sv
module tpat_expect
   import tpat_pkg::*;
#(
   parameter int DW     = 12,
   parameter int HOLD_N = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          drop,
   input  pat_mode_e     mode,
   input  logic [DW-1:0] custom_word,
   input  logic          vld,
   input  logic [DW-1:0] data,
   output logic          cmp_vld,
   output logic          cmp_hit
);
   localparam int RW = $clog2(HOLD_N + 1);
   localparam logic [DW-1:0] ALT_A = {(DW/2){2'b01}};
   localparam logic [DW-1:0] ALT_B = {(DW/2){2'b10}};

   if (DW < 12 || (DW % 2) != 0) begin : g_bad_dw
      $error("tpat_expect: DW must be even and at least 12");
   end
   if (HOLD_N < 1) begin : g_bad_hold
      $error("tpat_expect: HOLD_N must be at least 1");
   end

   logic [DW-1:0] sine_rom [SINE_LEN];
   for (genvar gi = 0; gi < SINE_LEN; gi++) begin : g_rom
      assign sine_rom[gi] = DW'(sine_code(gi));
   end

   logic          synced;
   logic          seeded;
   logic [DW-1:0] code_q;
   logic [RW-1:0] rep_q;
   logic [2:0]    idx_q;
   logic [DW-1:0] expect_w;

   always_comb begin
      case (mode)
         PAT_ALT:  expect_w = code_q;
         PAT_RAMP: expect_w = (rep_q == RW'(HOLD_N)) ? code_q + DW'(1) : code_q;
         PAT_SINE: expect_w = sine_rom[idx_q];
         default:  expect_w = custom_word;
      endcase
   end

   assign cmp_vld = vld && !flush && (synced || mode == PAT_CUSTOM);
   assign cmp_hit = (data == expect_w);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         synced <= 1'b0;
         seeded <= 1'b0;
         code_q <= '0;
         rep_q  <= '0;
         idx_q  <= '0;
      end else if (flush || drop) begin
         synced <= 1'b0;
         seeded <= 1'b0;
      end else if (vld) begin
         case (mode)
            PAT_ALT: begin
               if (synced) begin
                  code_q <= ~expect_w;
               end else if (data == ALT_A || data == ALT_B) begin
                  synced <= 1'b1;
                  code_q <= ~data;
               end
            end
            PAT_RAMP: begin
               if (synced) begin
                  if (rep_q == RW'(HOLD_N)) begin
                     code_q <= code_q + DW'(1);
                     rep_q  <= RW'(1);
                  end else begin
                     rep_q <= rep_q + RW'(1);
                  end
               end else if (!seeded) begin
                  seeded <= 1'b1;
                  code_q <= data;
               end else if (data == code_q + DW'(1)) begin
                  synced <= 1'b1;
                  code_q <= data;
                  rep_q  <= RW'(1);
               end else if (data != code_q) begin
                  code_q <= data;
               end
            end
            PAT_SINE: begin
               if (synced) begin
                  idx_q <= idx_q + 3'd1;
               end else if (data == sine_rom[0]) begin
                  synced <= 1'b1;
                  idx_q  <= 3'd1;
               end
            end
            default: ;
         endcase
      end
   end

   // A compared ramp sample never finds the run counter outside 1..HOLD_N.
   AST_RAMP_REP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_vld && mode == PAT_RAMP) |-> (rep_q >= RW'(1) && rep_q <= RW'(HOLD_N))); // R3

endmodule

// File: rtl/tpat_lock.sv
module tpat_lock #(
   parameter int LOCK_N = 16,
   parameter int DROP_N = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic cmp_vld,
   input  logic cmp_hit,
   output logic locked,
   output logic drop,
   output logic err
);
   localparam int HW = $clog2(LOCK_N);
   localparam int MW = $clog2(DROP_N);

   if (LOCK_N < 2 || DROP_N < 2) begin : g_bad_thr
      $error("tpat_lock: LOCK_N and DROP_N must be at least 2");
   end

   logic [HW-1:0] hit_run;
   logic [MW-1:0] miss_run;
   logic          miss;

   assign miss = cmp_vld && !cmp_hit;
   assign err  = miss && locked;
   assign drop = miss && (!locked || miss_run == MW'(DROP_N - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         locked   <= 1'b0;
         hit_run  <= '0;
         miss_run <= '0;
      end else if (cmp_vld) begin
         if (!locked) begin
            if (!cmp_hit) begin
               hit_run <= '0;
            end else if (hit_run == HW'(LOCK_N - 1)) begin
               locked   <= 1'b1;
               hit_run  <= '0;
               miss_run <= '0;
            end else begin
               hit_run <= hit_run + HW'(1);
            end
         end else if (cmp_hit) begin
            miss_run <= '0;
         end else if (miss_run == MW'(DROP_N - 1)) begin
            locked   <= 1'b0;
            miss_run <= '0;
            hit_run  <= '0;
         end else begin
            miss_run <= miss_run + MW'(1);
         end
      end
   end

   AST_LOCK_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(cmp_vld && cmp_hit)); // R6

   AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(flush || (cmp_vld && !cmp_hit))); // R7

endmodule

// File: rtl/tpat_errcnt.sv
module tpat_errcnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   if (CNT_W < 1) begin : g_bad_w
      $error("tpat_errcnt: CNT_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         count <= '0;
      end else if (inc && count != TOP) begin
         count <= count + CNT_W'(1);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (count == TOP && !clr) |=> count == TOP); // R9

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (count == $past(count) || count == $past(count) + CNT_W'(1))); // R8

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0); // R10

endmodule

// File: rtl/tpat_checker.sv
module tpat_checker
   import tpat_pkg::*;
#(
   parameter int DW     = 12,
   parameter int HOLD_N = 4,
   parameter int LOCK_N = 16,
   parameter int DROP_N = 4,
   parameter int CNT_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [1:0]       mode,
   input  logic [DW-1:0]    custom_word,
   input  logic             smp_valid,
   input  logic [DW-1:0]    smp_data,
   output logic             locked,
   output logic             err_pulse,
   output logic [CNT_W-1:0] err_count
);
   pat_mode_e mode_now;
   pat_mode_e mode_q;
   logic      flush;
   logic      cmp_vld;
   logic      cmp_hit;
   logic      drop;
   logic      err;

   assign mode_now = pat_mode_e'(mode);
   assign flush    = (mode_now != mode_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= PAT_ALT;
         err_pulse <= 1'b0;
      end else begin
         mode_q    <= mode_now;
         err_pulse <= err;
      end
   end

   tpat_expect #(.DW(DW), .HOLD_N(HOLD_N)) u_expect (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .drop        (drop),
      .mode        (mode_now),
      .custom_word (custom_word),
      .vld         (smp_valid),
      .data        (smp_data),
      .cmp_vld     (cmp_vld),
      .cmp_hit     (cmp_hit)
   );

   tpat_lock #(.LOCK_N(LOCK_N), .DROP_N(DROP_N)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .cmp_vld (cmp_vld),
      .cmp_hit (cmp_hit),
      .locked  (locked),
      .drop    (drop),
      .err     (err)
   );

   tpat_errcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr || flush),
      .inc   (err),
      .count (err_count)
   );

   AST_ERR_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> $past(locked)); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> !err_pulse); // R11

   AST_PULSE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      (err_pulse && !$past(clr) && $past(err_count) != {CNT_W{1'b1}})
         |-> err_count == $past(err_count) + CNT_W'(1)); // R8

endmodule

// File: tb/sim_tpat_checker.sv
`timescale 1ns/1ps
module sim_tpat_checker;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic [11:0]   cword = 12'h000;
   logic          sv = 1'b0;
   logic [11:0]   sd = 12'h000;
   logic          locked;
   logic          errp;
   logic [CW-1:0] ecnt;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   logic [11:0] w0;

   always #2 clk = ~clk;

   tpat_checker #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .custom_word(cword),
      .smp_valid(sv), .smp_data(sd), .locked(locked), .err_pulse(errp),
      .err_count(ecnt)
   );

   function automatic logic [11:0] sine_ref(input int i);
      case (i % 8)
         0: return 12'd1384;  1: return 12'd978;
         2: return 12'd0;     3: return 12'd3117;
         4: return 12'd2711;  5: return 12'd3117;
         6: return 12'd0;     default: return 12'd978;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [11:0] d);
      @(negedge clk);
      sv = v;
      sd = d;
      @(posedge clk);
      #1;
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      mode = m;
      sv = 1'b0;
      @(posedge clk);
      #1;
   endtask

   task automatic hits(input int k);
      for (int i = 0; i < k; i++) step(1'b1, cword);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 locked after reset", locked, 0);
      chk("R1 err_pulse after reset", errp, 0);
      chk("R1 err_count after reset", ecnt, 0);

      // R2: both legal start words
      for (int s = 0; s < 2; s++) begin
         w0 = (s == 0) ? 12'h555 : 12'hAAA;
         set_mode(2'd3);
         set_mode(2'd0);
         for (int n = 0; n <= 16; n++) begin
            step(1'b1, (n % 2 == 1) ? ~w0 : w0);
            if (n == 15) chk("R6 alt not yet locked", locked, 0);
            if (n == 16) chk("R2 alt locked", locked, 1);
         end
         step(1'b1, w0);
         chk("R8 alt error pulse", errp, 1);
         chk("R7 alt error count", ecnt, 1);
         step(1'b1, w0);
         chk("R2 alt toggle continues", errp, 0);
         chk("R2 alt still locked", locked, 1);
      end

      // R2: an illegal first word is skipped
      set_mode(2'd3);
      set_mode(2'd0);
      step(1'b1, 12'h123);
      for (int n = 0; n <= 16; n++) begin
         step(1'b1, (n % 2 == 1) ? 12'hAAA : 12'h555);
         if (n == 15) chk("R2 skipped word not seeded", locked, 0);
         if (n == 16) chk("R2 lock after skip", locked, 1);
      end

      // R3: all ramp phases across the wrap
      for (int ph = 0; ph < 4; ph++) begin
         set_mode(2'd0);
         set_mode(2'd1);
         for (int n = 0; n < 40; n++) begin
            step(1'b1, 12'((4090 + (n + ph) / 4) % 4096));
            if (n == 19 - ph) chk("R3 ramp not yet locked", locked, 0);
            if (n == 20 - ph) chk("R3 ramp locked", locked, 1);
         end
         chk("R3 ramp wrap no errors", ecnt, 0);
         chk("R3 ramp locked after wrap", locked, 1);
      end

      // R3: a ramp stepping every sample is rejected
      set_mode(2'd0);
      set_mode(2'd1);
      for (int n = 0; n < 40; n++) step(1'b1, 12'(n + 100));
      chk("R3 fast ramp never locks", locked, 0);

      // R4: all sine phases
      for (int ph = 0; ph < 8; ph++) begin
         int sy;
         sy = (8 - ph) % 8;
         set_mode(2'd0);
         set_mode(2'd2);
         for (int n = 0; n <= sy + 20; n++) begin
            step(1'b1, sine_ref(n + ph));
            if (n == sy + 15) chk("R4 sine not yet locked", locked, 0);
            if (n == sy + 16) chk("R4 sine locked", locked, 1);
         end
         step(1'b1, 12'd5);
         chk("R4 sine error pulse", errp, 1);
         chk("R4 sine error count", ecnt, 1);
         step(1'b1, sine_ref(sy + 22 + ph));
         chk("R4 sine resumes", errp, 0);
      end

      // R5, R6, R7, R11 in custom mode
      set_mode(2'd3);
      cword = 12'h123;
      for (int n = 1; n <= 16; n++) begin
         step(1'b1, cword);
         if (n == 15) chk("R6 custom not yet locked", locked, 0);
         if (n == 16) chk("R5 custom locked", locked, 1);
      end
      for (int k = 1; k <= 3; k++) begin
         step(1'b1, 12'h124);
         chk("R7 miss counted", ecnt, k);
         chk("R7 lock held", locked, 1);
      end
      step(1'b0, 12'hFFF);
      chk("R11 idle no pulse", errp, 0);
      chk("R11 idle no count", ecnt, 3);
      step(1'b1, 12'h124);
      chk("R7 fourth miss counted", ecnt, 4);
      chk("R7 lock dropped", locked, 0);
      step(1'b1, 12'h124);
      step(1'b1, 12'h124);
      chk("R7 unlocked miss not pulsed", errp, 0);
      chk("R7 unlocked miss not counted", ecnt, 4);

      // R9: saturation of the narrow counter
      for (int r = 0; r < 4; r++) begin
         hits(16);
         for (int k = 0; k < 4; k++) step(1'b1, 12'h000);
         chk("R9 count saturates", ecnt, (8 + 4 * r > 15) ? 15 : 8 + 4 * r);
      end
      chk("R8 pulse at saturation", errp, 1);

      // R10: clear and mode change
      hits(16);
      @(negedge clk);
      clr = 1'b1;
      sv = 1'b0;
      @(posedge clk);
      #1;
      clr = 1'b0;
      chk("R10 clr zeroes count", ecnt, 0);
      chk("R10 clr keeps lock", locked, 1);
      step(1'b1, 12'h000);
      chk("R8 count after clr", ecnt, 1);
      set_mode(2'd1);
      chk("R10 mode change zeroes count", ecnt, 0);
      chk("R10 mode change drops lock", locked, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule